// File: doc/BRIEF.md
# Tournament Hybrid Branch Direction Predictor

This block predicts the direction of conditional branches by running two direction predictors side by side and letting a trained chooser pick between them for each branch. The first component is a per-address table of 2-bit saturating counters. It warms up within a few executions of a branch. The second component keeps a shift register of the most recent resolved outcomes and uses that history alone to index its own table of 2-bit counters. This lets it capture patterns that correlate across branches or repeat over time. A third table of 2-bit chooser counters, indexed by branch address, learns which component to trust for that branch.

A fetch stage presents a lookup PC every cycle. One cycle later the block returns the final direction, the component that was chosen, and both component directions. The pipeline carries the component directions along with the branch. When the branch resolves, the pipeline returns the PC, the real outcome and the two carried component directions on the resolve port. The block then trains all three tables and shifts the history. A context-switch flush returns every table and the history to their start state, so one program's training cannot affect another.

Top module: `tourney_bp`

## Requirements
- R1: After reset, every lookup returns pred_taken=0, pred_use_glob=0, pred_bim=0 and pred_glob=0. The start state is: all component counters at 1 (weakly not-taken), all chooser counters at 1 (weakly bimodal), and the history at 0.
- R2: A lookup PC presented before a clock edge produces its outputs in registers at that edge. The outputs reflect the table and history state from before any resolve applied at the same edge.
- R3: The bimodal counter is selected by rs_pc[BIM_IDX_W-1:0] on resolve and by lk_pc[BIM_IDX_W-1:0] on lookup. It is incremented when rs_taken=1 and decremented when rs_taken=0 on every valid resolve. Its direction is taken when the counter is 2 or more.
- R4: The history register is HIST_W bits wide and shifts each resolved outcome in at bit 0. The global counter table is indexed by the history value alone. On resolve, the counter at the history value from before the shift is incremented when the branch was taken and decremented when it was not.
- R5: The chooser counter is selected by PC bits [SEL_IDX_W-1:0]. A value of 2 or more selects the global component (pred_use_glob=1). On resolve it increments when only the global direction matched the outcome and decrements when only the bimodal direction matched. It is unchanged when both matched or neither matched.
- R6: pred_taken equals pred_glob when pred_use_glob=1 and pred_bim otherwise.
- R7: flush=1 at a clock edge returns all tables, the history and the outputs to the R1 state. This takes priority over a resolve presented at the same edge.
- R8: All 2-bit counters saturate at 3 when incremented and at 0 when decremented; they never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Context switch: clear all predictor state |
| lk_pc | input | PC_W | Lookup branch address |
| rs_valid | input | 1 | Resolve strobe |
| rs_pc | input | PC_W | Address of the resolved branch |
| rs_taken | input | 1 | Actual outcome of the resolved branch |
| rs_bim_pred | input | 1 | Bimodal direction given for that branch at lookup |
| rs_glob_pred | input | 1 | Global direction given for that branch at lookup |
| pred_taken | output | 1 | Final predicted direction |
| pred_use_glob | output | 1 | 1 when the global component was chosen |
| pred_bim | output | 1 | Bimodal component direction |
| pred_glob | output | 1 | Global component direction |

## Verification
The hardest state to reach is a chooser counter that switches over and then switches back. This needs a run of resolves in which exactly one component was right, and in natural traffic both components usually agree. The bench therefore drives the resolve port directly with chosen component directions as well as with the directions a real pipeline would return. It uses a disagreeing pair to push a chooser entry to its top and back across the threshold, and an agreeing-but-wrong pair to show that the entry does not move. Saturation is reached by repeating one outcome past the counter range and then reversing it once, so a wrapped counter would show up as the wrong direction.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_WEAK_LOW = 2'd1;

  function automatic ctr2_t sat_step(input ctr2_t c, input logic up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    else    return (c == 2'd0) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/ctr_table.sv
module ctr_table
  import tbp_pkg::*;
#(
  parameter int    IDX_W = 6,
  parameter ctr2_t INIT  = CTR_WEAK_LOW
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr2_t            rd_val,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  localparam int DEPTH = 1 << IDX_W;

  ctr2_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= INIT;
    end else if (wr_en) begin
      mem[wr_idx] <= sat_step(mem[wr_idx], wr_up);
    end
  end

  assign rd_val = mem[rd_idx];

  // R8: counter at top stays at top when pushed up
  p_sat_top_r8: assert property (@(posedge clk) disable iff (clr)
    (wr_en && wr_up && mem[wr_idx] == 2'd3) |=> mem[$past(wr_idx)] == 2'd3);

  // R8: counter at bottom stays at bottom when pushed down
  p_sat_bot_r8: assert property (@(posedge clk) disable iff (clr)
    (wr_en && !wr_up && mem[wr_idx] == 2'd0) |=> mem[$past(wr_idx)] == 2'd0);

  // R5: with no write, an entry keeps its value
  p_hold_r5: assert property (@(posedge clk) disable iff (clr)
    !wr_en |=> mem[$past(rd_idx)] == $past(rd_val));

  // R7: clear puts the start value in every entry
  p_clear_r7: assert property (@(posedge clk)
    clr |=> (mem[0] == INIT && mem[DEPTH-1] == INIT));
endmodule

// File: rtl/hist_reg.sv
module hist_reg #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] hist
);
  always_ff @(posedge clk) begin
    if (clr)           hist <= '0;
    else if (shift_en) hist <= {hist[W-2:0], bit_in};
  end

  // R4: newest outcome lands at bit 0, older bits move up
  p_shift_r4: assert property (@(posedge clk) disable iff (clr)
    shift_en |=> (hist[0] == $past(bit_in) && hist[W-1:1] == $past(hist[W-2:0])));

  // R4: history only changes on a resolve
  p_hold_r4: assert property (@(posedge clk) disable iff (clr)
    !shift_en |=> $stable(hist));

  // R7: clear empties the history
  p_clear_r7: assert property (@(posedge clk) clr |=> hist == '0);
endmodule

// File: rtl/tourney_bp.sv
module tourney_bp
  import tbp_pkg::*;
#(
  parameter int PC_W      = 16,
  parameter int BIM_IDX_W = 6,
  parameter int HIST_W    = 6,
  parameter int SEL_IDX_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic [PC_W-1:0] lk_pc,
  input  logic            rs_valid,
  input  logic [PC_W-1:0] rs_pc,
  input  logic            rs_taken,
  input  logic            rs_bim_pred,
  input  logic            rs_glob_pred,
  output logic            pred_taken,
  output logic            pred_use_glob,
  output logic            pred_bim,
  output logic            pred_glob
);
  logic              clr;
  logic [HIST_W-1:0] ghist;
  ctr2_t             bim_rd, glob_rd, sel_rd;
  logic              sel_wr_en, sel_wr_up;

  assign clr       = rst | flush;
  assign sel_wr_en = rs_valid && (rs_bim_pred != rs_glob_pred);
  assign sel_wr_up = (rs_glob_pred == rs_taken);

  ctr_table #(.IDX_W(BIM_IDX_W), .INIT(CTR_WEAK_LOW)) u_bim (
    .clk(clk), .clr(clr),
    .rd_idx(lk_pc[BIM_IDX_W-1:0]), .rd_val(bim_rd),
    .wr_en(rs_valid), .wr_idx(rs_pc[BIM_IDX_W-1:0]), .wr_up(rs_taken)
  );

  ctr_table #(.IDX_W(HIST_W), .INIT(CTR_WEAK_LOW)) u_glob (
    .clk(clk), .clr(clr),
    .rd_idx(ghist), .rd_val(glob_rd),
    .wr_en(rs_valid), .wr_idx(ghist), .wr_up(rs_taken)
  );

  ctr_table #(.IDX_W(SEL_IDX_W), .INIT(CTR_WEAK_LOW)) u_sel (
    .clk(clk), .clr(clr),
    .rd_idx(lk_pc[SEL_IDX_W-1:0]), .rd_val(sel_rd),
    .wr_en(sel_wr_en), .wr_idx(rs_pc[SEL_IDX_W-1:0]), .wr_up(sel_wr_up)
  );

  hist_reg #(.W(HIST_W)) u_hist (
    .clk(clk), .clr(clr), .shift_en(rs_valid), .bit_in(rs_taken), .hist(ghist)
  );

  always_ff @(posedge clk) begin
    if (clr) begin
      pred_taken    <= 1'b0;
      pred_use_glob <= 1'b0;
      pred_bim      <= 1'b0;
      pred_glob     <= 1'b0;
    end else begin
      pred_bim      <= bim_rd[1];
      pred_glob     <= glob_rd[1];
      pred_use_glob <= sel_rd[1];
      pred_taken    <= sel_rd[1] ? glob_rd[1] : bim_rd[1];
    end
  end

  // R6: final direction follows the chosen component
  p_final_sel_r6: assert property (@(posedge clk) disable iff (rst)
    pred_taken == (pred_use_glob ? pred_glob : pred_bim));

  // R7: flush returns the outputs to the start state
  p_flush_out_r7: assert property (@(posedge clk)
    flush |=> (!pred_taken && !pred_use_glob && !pred_bim && !pred_glob));
endmodule

// File: tb/tb_tourney_bp.sv
`timescale 1ns/1ps
module tb_tourney_bp;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic [15:0] lk_pc = '0;
  logic        rs_valid = 1'b0;
  logic [15:0] rs_pc = '0;
  logic        rs_taken = 1'b0;
  logic        rs_bim_pred = 1'b0;
  logic        rs_glob_pred = 1'b0;
  logic        pred_taken, pred_use_glob, pred_bim, pred_glob;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  tourney_bp dut (
    .clk(clk), .rst(rst), .flush(flush), .lk_pc(lk_pc),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken),
    .rs_bim_pred(rs_bim_pred), .rs_glob_pred(rs_glob_pred),
    .pred_taken(pred_taken), .pred_use_glob(pred_use_glob),
    .pred_bim(pred_bim), .pred_glob(pred_glob)
  );

  // reference model built from the requirements
  int bm [64];
  int gm [64];
  int sm [64];
  logic [5:0] gh;

  function automatic int sat(input int c, input logic up);
    if (up) return (c == 3) ? 3 : c + 1;
    else    return (c == 0) ? 0 : c - 1;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 64; i++) begin bm[i] = 1; gm[i] = 1; sm[i] = 1; end
    gh = '0;
  endtask

  function automatic logic [3:0] model_look(input logic [15:0] pc);
    logic b, g, s;
    b = (bm[pc[5:0]] >= 2);
    g = (gm[gh] >= 2);
    s = (sm[pc[5:0]] >= 2);
    return {(s ? g : b), s, b, g};
  endfunction

  task automatic model_update(input logic [15:0] pc, input logic t,
                              input logic bp, input logic gp);
    bm[pc[5:0]] = sat(bm[pc[5:0]], t);
    gm[gh] = sat(gm[gh], t);
    if (bp != gp) sm[pc[5:0]] = sat(sm[pc[5:0]], gp == t);
    gh = {gh[4:0], t};
  endtask

  task automatic check(input string tag, input logic [3:0] exp);
    logic [3:0] got;
    got = {pred_taken, pred_use_glob, pred_bim, pred_glob};
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got={taken,glob,bim,gdir}=%b exp=%b", tag, got, exp);
    end
  endtask

  // one cycle: lookup lpc, optional resolve, optional flush, then check
  task automatic step(input string tag, input logic [15:0] lpc, input logic rv,
                      input logic [15:0] rpc, input logic t, input logic bp,
                      input logic gp, input logic fl);
    logic [3:0] exp;
    @(negedge clk);
    lk_pc = lpc; rs_valid = rv; rs_pc = rpc; rs_taken = t;
    rs_bim_pred = bp; rs_glob_pred = gp; flush = fl;
    exp = fl ? 4'b0000 : model_look(lpc);
    if (fl) model_clear();
    else if (rv) model_update(rpc, t, bp, gp);
    @(posedge clk);
    #1;
    check(tag, exp);
    rs_valid = 1'b0; flush = 1'b0;
  endtask

  // lookup and resolve of the same branch with the directions a pipeline would carry
  task automatic step_nat(input string tag, input logic [15:0] pc, input logic t);
    step(tag, pc, 1'b1, pc, t, bm[pc[5:0]] >= 2, gm[gh] >= 2, 1'b0);
  endtask

  typedef struct packed { logic [15:0] pc; logic t; } vec_t;
  localparam vec_t VECS [0:23] = '{
    '{16'h0010, 1'b1}, '{16'h0010, 1'b0}, '{16'h0010, 1'b1}, '{16'h0010, 1'b0},
    '{16'h0010, 1'b1}, '{16'h0010, 1'b0}, '{16'h0010, 1'b1}, '{16'h0010, 1'b0},
    '{16'h0023, 1'b1}, '{16'h0023, 1'b1}, '{16'h0023, 1'b1}, '{16'h0063, 1'b0},
    '{16'h0010, 1'b1}, '{16'h0010, 1'b0}, '{16'h0010, 1'b1}, '{16'h0010, 1'b0},
    '{16'h0010, 1'b1}, '{16'h0010, 1'b0}, '{16'h0010, 1'b1}, '{16'h0010, 1'b0},
    '{16'h1010, 1'b1}, '{16'h0023, 1'b0}, '{16'h0010, 1'b1}, '{16'h0010, 1'b0}
  };

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: start state seen at the outputs
    step("R1 reset state", 16'h0011, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    step("R1 reset state other pc", 16'h003f, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);

    // vector walk: R3 bimodal, R4 history-indexed table, R5 chooser, R6 final mux
    foreach (VECS[i]) step_nat($sformatf("R3/R4/R5/R6 vector %0d", i), VECS[i].pc, VECS[i].t);

    // R8: saturation high, then one reversal keeps taken
    model_clear();
    step("R7 flush", 16'h0005, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1);
    for (int k = 0; k < 5; k++) step_nat("R8 push up", 16'h0005, 1'b1);
    step_nat("R8 one down", 16'h0005, 1'b0);
    step("R8 top held (bim still taken)", 16'h0005, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    // R8: saturation low, then one reversal keeps not-taken
    for (int k = 0; k < 5; k++) step_nat("R8 push down", 16'h0006, 1'b0);
    step_nat("R8 one up", 16'h0006, 1'b1);
    step("R8 bottom held (bim not taken)", 16'h0006, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);

    // R5: both agree and wrong -> chooser unchanged
    for (int k = 0; k < 3; k++)
      step("R5 agree-wrong hold", 16'h0007, 1'b1, 16'h0007, 1'b0, 1'b1, 1'b1, 1'b0);
    step("R5 chooser still bimodal", 16'h0007, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    // R5: only global right twice -> switch to global
    step("R5 glob right 1", 16'h0009, 1'b1, 16'h0009, 1'b1, 1'b0, 1'b1, 1'b0);
    step("R5 glob right 2", 16'h0009, 1'b1, 16'h0009, 1'b1, 1'b0, 1'b1, 1'b0);
    step("R5 global chosen", 16'h0009, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    // R5: only bimodal right -> back across the threshold in two steps
    step("R5 bim right 1", 16'h0009, 1'b1, 16'h0009, 1'b0, 1'b0, 1'b1, 1'b0);
    step("R5 still global", 16'h0009, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    step("R5 bim right 2", 16'h0009, 1'b1, 16'h0009, 1'b0, 1'b0, 1'b1, 1'b0);
    step("R5 back to bimodal", 16'h0009, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);

    // R2: same-edge lookup and resolve of one branch sees old state
    step_nat("R2 prime", 16'h000c, 1'b1);
    step_nat("R2 same-edge", 16'h000c, 1'b1);
    step("R2 after update", 16'h000c, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);

    // R7: flush with a same-cycle resolve wins and clears everything
    step("R7 flush beats resolve", 16'h000c, 1'b1, 16'h000c, 1'b1, 1'b1, 1'b1, 1'b1);
    step("R7 cleared bim", 16'h000c, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    step("R7 cleared chooser", 16'h0009, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);

    // R1: reset after training returns to start state
    step_nat("R1 train", 16'h0015, 1'b1);
    step_nat("R1 train", 16'h0015, 1'b1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; model_clear();
    step("R1 after reset", 16'h0015, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule